// File: doc/BRIEF.md
# Calibrated Error-Feedback Requantizer

This block turns a stream of high-resolution signed fixed-point samples into signed 16-bit converter codes. It uses second-order error-feedback noise shaping. The error fed back is not the plain rounding error. It is the difference between the converter's estimated true output level and the quantizer input. The estimate is the ideal level of the chosen code plus a measured correction read from a level-error table. In this way the static level mismatch of the converter is pushed into the same high-pass shaped noise as the rounding error, and a later reconstruction filter removes that noise.

All arithmetic is done in units of one converter step (LSB) with `FRAC` fractional bits. A triangular dither spanning just under plus or minus one LSB is added before rounding. The dither comes from the difference of two uniform values taken from two free-running shift registers.

The correction table is loaded through a write port while the loop is held in reset. Each table entry covers a segment of `2**(CODE_W-TBL_AW)` consecutive codes. Setting `TBL_AW = CODE_W` gives one entry per code. Each accepted sample produces one code one cycle later.

Top module: `ef_requant`

## Requirements
- R1: The code is the floor of (w + half LSB), where w is the quantizer input in LSB units with FRAC fractional bits. This is mid-tread rounding, and ties round toward plus infinity.
- R2: The quantizer input is w = x + d - (2*e[n-1] - e[n-2]), where e[n-1] and e[n-2] are the two most recent stored errors.
- R3: The stored error is e = k*2^FRAC + c - w, where k is the code and c is the signed table entry.
  - The table index is formed by inverting the code's sign bit and taking the top TBL_AW bits of the result.
  - With the default parameters, index 0 covers codes -32768 to -32513.
- R4: The dither is d = A[FRAC-1:0] - B[FRAC-1:0], both read as unsigned.
  - A and B are 16-bit shift registers that shift left, with the new bit entering at bit 0.
  - A uses feedback bit A[15]^A[13]^A[12]^A[10] and resets to 16'hACE1.
  - B uses feedback bit B[15]^B[14]^B[12]^B[3] and resets to 16'h1D2B.
  - Both registers advance once per accepted sample, after being used for that sample.
- R5: The code saturates to the range -2^(CODE_W-1) to 2^(CODE_W-1)-1. On a saturated sample, the stored error is clipped to plus or minus one LSB (plus or minus 2^FRAC).
- R6: The out_valid and out_code outputs follow an accepted sample (in_valid high) by exactly one cycle.
  - Without in_valid, out_valid is low the next cycle.
  - Without in_valid, the error registers, the dither registers and out_code hold their values.
- R7: A table write (tbl_we) takes effect only while rst_n is low. A write while rst_n is high changes nothing.
- R8: Reset clears both error registers, reloads both dither seeds, and drives out_valid and out_code to zero. Reset does not clear the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low loop reset; also enables table writes |
| in_valid | input | 1 | Input sample is present |
| in_x | input | CODE_W+FRAC | Signed sample in LSB units with FRAC fractional bits |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | TBL_AW | Table segment index |
| tbl_data | input | CORR_W | Signed level correction in LSB units with FRAC fractional bits |
| out_valid | output | 1 | Output code is present |
| out_code | output | CODE_W | Signed converter code |

## Verification
The constant-input run with an all-zero table isolates the rounding, dither and feedback recursion from the table path. Any error in the shift-register sequence or the filter taps appears within a few samples. The triangle-wave run with a non-uniform table visits many segments, so it separates a correct index and sign convention from an off-by-one or unsigned lookup. Inputs driven against both full-scale limits expose saturation and the error clip. A write issued while the loop runs, a burst with idle gaps, and a mid-stream reset followed by a repeated pattern each distinguish the write gating, the hold behaviour and the state clearing from designs that leak state.

// File: rtl/ef_requant.sv
module ef_requant #(
  parameter int CODE_W = 16,
  parameter int FRAC   = 8,
  parameter int TBL_AW = 8,
  parameter int CORR_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [CODE_W+FRAC-1:0]   in_x,
  input  logic                     tbl_we,
  input  logic [TBL_AW-1:0]        tbl_addr,
  input  logic [CORR_W-1:0]        tbl_data,
  output logic                     out_valid,
  output logic [CODE_W-1:0]        out_code
);
  localparam int XW    = CODE_W + FRAC;
  localparam int AW    = CODE_W + FRAC + 4;
  localparam int TBL_N = 1 << TBL_AW;
  localparam logic signed [AW-1:0] HALF = AW'(2 ** (FRAC - 1));
  localparam logic signed [AW-1:0] ELIM = AW'(2 ** FRAC);
  localparam logic signed [AW-1:0] KMAX = AW'(2 ** (CODE_W - 1) - 1);
  localparam logic signed [AW-1:0] KMIN = -AW'(2 ** (CODE_W - 1));
  localparam logic [15:0] SEED_A = 16'hACE1;
  localparam logic [15:0] SEED_B = 16'h1D2B;

  logic [CORR_W-1:0] tbl [TBL_N];
  logic signed [AW-1:0] e1, e2;
  logic [15:0] lfa, lfb;

  logic signed [FRAC+1:0] dith;
  logic signed [AW-1:0] fb, w, kr, est, err, err_st, corr_x;
  logic signed [CODE_W-1:0] k;
  logic [CODE_W-1:0] k_off;
  logic [TBL_AW-1:0] idx;
  logic sat_hi, sat_lo;

  assign dith = $signed({2'b00, lfa[FRAC-1:0]}) - $signed({2'b00, lfb[FRAC-1:0]});
  assign fb   = (e1 <<< 1) - e2;
  assign w    = $signed({{(AW-XW){in_x[XW-1]}}, in_x})
              + $signed({{(AW-FRAC-2){dith[FRAC+1]}}, dith}) - fb;
  assign kr   = (w + HALF) >>> FRAC;

  assign sat_hi = kr > KMAX;
  assign sat_lo = kr < KMIN;
  assign k = sat_hi ? KMAX[CODE_W-1:0] : (sat_lo ? KMIN[CODE_W-1:0] : kr[CODE_W-1:0]);

  assign k_off  = {~k[CODE_W-1], k[CODE_W-2:0]};
  assign idx    = k_off[CODE_W-1 -: TBL_AW];
  assign corr_x = $signed({{(AW-CORR_W){tbl[idx][CORR_W-1]}}, tbl[idx]});
  assign est    = ($signed({{(AW-CODE_W){k[CODE_W-1]}}, k}) <<< FRAC) + corr_x;
  assign err    = est - w;

  always_comb begin
    err_st = err;
    if (sat_hi || sat_lo) begin
      if (err > ELIM)       err_st = ELIM;
      else if (err < -ELIM) err_st = -ELIM;
    end
  end

  always_ff @(posedge clk)
    if (!rst_n && tbl_we) tbl[tbl_addr] <= tbl_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1        <= '0;
      e2        <= '0;
      lfa       <= SEED_A;
      lfb       <= SEED_B;
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        e2       <= e1;
        e1       <= err_st;
        lfa      <= {lfa[14:0], lfa[15] ^ lfa[13] ^ lfa[12] ^ lfa[10]};
        lfb      <= {lfb[14:0], lfb[15] ^ lfb[14] ^ lfb[12] ^ lfb[3]};
        out_code <= k;
      end
    end
  end

  // R5: a saturated sample leaves at most one LSB of error in the loop
  p_sat_clip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (sat_hi || sat_lo) |=> (e1 <= ELIM) && (e1 >= -ELIM));

  // R6: one-cycle output timing
  p_valid_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(e1) && $stable(e2) && $stable(lfa) && $stable(out_code));

  // R2: the older error tap is the previous newer tap
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> e2 == $past(e1));

  // R4: the dither registers never lock up at zero
  p_lfsr_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lfa != 16'h0) && (lfb != 16'h0));

  // R8: the loop leaves reset with clean error state
  p_rst_clear_r8: assert property (@(posedge clk)
    $rose(rst_n) |-> (e1 == '0) && (e2 == '0) && !out_valid);
endmodule

// File: tb/ef_requant_bench.sv
module ef_requant_bench;
  localparam int CODE_W = 16;
  localparam int FRAC   = 8;
  localparam int TBL_AW = 8;
  localparam int CORR_W = 16;
  localparam int TBL_N  = 1 << TBL_AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [CODE_W+FRAC-1:0] in_x = '0;
  logic tbl_we = 1'b0;
  logic [TBL_AW-1:0] tbl_addr = '0;
  logic [CORR_W-1:0] tbl_data = '0;
  logic out_valid;
  logic [CODE_W-1:0] out_code;

  ef_requant #(.CODE_W(CODE_W), .FRAC(FRAC), .TBL_AW(TBL_AW), .CORR_W(CORR_W)) u_ef_requant (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .out_valid(out_valid), .out_code(out_code));

  int n_run = 0, n_fail = 0, n_sat_hi = 0, n_sat_lo = 0;
  longint q_exp[$];
  longint me1, me2, mtbl[TBL_N];
  logic [15:0] ma, mb;
  bit done = 0;

  task automatic model_reset();
    me1 = 0; me2 = 0; ma = 16'hACE1; mb = 16'h1D2B;
  endtask

  // Expected code per R1..R5
  function automatic longint model_step(longint x);
    longint d, fb, w, k, idx, e, lim;
    lim = 1 << FRAC;
    d = longint'(ma[FRAC-1:0]) - longint'(mb[FRAC-1:0]);  // R4
    fb = 2 * me1 - me2;                                     // R2
    w = x + d - fb;
    k = (w + (1 << (FRAC - 1))) >>> FRAC;                   // R1
    if (k > 32767) begin k = 32767; n_sat_hi++; end         // R5
    else if (k < -32768) begin k = -32768; n_sat_lo++; end
    idx = (k + 32768) >> (CODE_W - TBL_AW);                 // R3
    e = k * lim + mtbl[idx] - w;
    if (k == 32767 || k == -32768) begin
      if ((w + (1 << (FRAC - 1))) >>> FRAC != k) begin
        if (e > lim) e = lim;
        if (e < -lim) e = -lim;
      end
    end
    me2 = me1; me1 = e;
    ma = {ma[14:0], ma[15] ^ ma[13] ^ ma[12] ^ ma[10]};
    mb = {mb[14:0], mb[15] ^ mb[14] ^ mb[12] ^ mb[3]};
    return k;
  endfunction

  task automatic check(bit ok, string req, longint got, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic send(longint x);
    q_exp.push_back(model_step(x));
    @(negedge clk);
    in_valid = 1'b1;
    in_x = x[CODE_W+FRAC-1:0];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: scoreboard pop and compare (R1 R2 R3 R4 R5 R6)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_exp.size() == 0) check(0, "R6 unexpected out_valid", 1, 0);
      else begin
        longint e;
        e = q_exp.pop_front();
        check(longint'($signed(out_code)) == e, "R1/R2/R3/R4/R5 code", longint'($signed(out_code)), e);
      end
    end
  end

  // R7/R8: load table only with loop in reset
  task automatic load_table(int pat);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    model_reset();
    for (int i = 0; i < TBL_N; i++) begin
      longint v;
      v = (pat == 0) ? 0 : (((i * 37) % 97) - 48) * 8;
      mtbl[i] = v;
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = TBL_AW'(i); tbl_data = CORR_W'(v);
    end
    @(negedge clk);
    tbl_we = 1'b0;
    check(out_valid == 1'b0, "R8 valid in reset", out_valid, 0);
    check(out_code == '0, "R8 code in reset", longint'($signed(out_code)), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    model_reset();
    for (int i = 0; i < TBL_N; i++) mtbl[i] = 0;

    // Pattern 1: constant input, zero table
    load_table(0);
    for (int i = 0; i < 200; i++) send(1000 * 256 + 64);
    idle(2);

    // Pattern 2: triangle sweep across many segments, patterned table
    load_table(1);
    for (int i = 0; i < 2000; i++) begin
      longint ph;
      ph = i % 400;
      send((ph < 200 ? ph : 400 - ph) * 30000 - 3000000 + 17);
    end
    idle(2);

    // R6: bursts with idle gaps hold state, out_valid low when idle
    for (int i = 0; i < 30; i++) begin
      send(-12345 * 256 + i * 7);
      idle(2);
      check(out_valid == 1'b0, "R6 idle valid", out_valid, 0);
    end

    // R7: write while running is ignored (index of codes near 1000 is 131)
    @(negedge clk);
    in_valid = 1'b0;
    tbl_we = 1'b1; tbl_addr = TBL_AW'(131); tbl_data = 16'h7000;
    @(negedge clk);
    tbl_we = 1'b0;
    for (int i = 0; i < 100; i++) send(1000 * 256 + 3);
    idle(2);

    // R5: drive both full-scale limits
    for (int i = 0; i < 150; i++) send(8388607);
    for (int i = 0; i < 150; i++) send(-8388608);
    for (int i = 0; i < 50; i++) send(32760 * 256);
    idle(2);
    n_run++; if (n_sat_hi == 0) begin n_fail++; $display("FAIL R5: high saturation got %0d expected >0", n_sat_hi); end
    n_run++; if (n_sat_lo == 0) begin n_fail++; $display("FAIL R5: low saturation got %0d expected >0", n_sat_lo); end

    // R8: mid-stream reset, table kept, sequence restarts identically
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid after reset", out_valid, 0);
    check(out_code == '0, "R8 code after reset", longint'($signed(out_code)), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) send(-500 * 256 - 100 + (i % 5) * 60);
    idle(3);
    check(q_exp.size() == 0, "R6 all outputs seen", q_exp.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(20 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule